// File: doc/BRIEF.md
# Programmable Network Status LED Driver

This block turns seven network status signals into the drive for one status LED. A host-programmed control register picks any subset of the sources. The block ORs the picked sources together. An optional stretcher lengthens short events until they are visible. A polarity bit sets whether the pin is active high or active low. The same register also reports the live, unstretched combined condition to the host.

The status sources are collision, jabber, receive activity, receive polarity reversed, transmit activity, address-matched receive and link pass. The receive polarity indication only counts while the link is good. The host writes the register through a simple write strobe and reads it back through a 32-bit read word. Only the asynchronous hard reset loads the register default. Soft reset and stop live outside this block and have no path into it.

Top module: `led_status_drv`

## Requirements
- R1: After hard reset the read word is 0x00000090 with all sources low: transmit activity enabled, stretcher enabled, active-low pin. The pin is high, meaning LED off.
- R2: Read bit 15 shows, in the same cycle, the OR of the enabled sources. The enable bits are bit 0 collision, bit 1 jabber, bit 2 receive, bit 3 receive polarity reversed, bit 4 transmit, bit 5 address-matched receive and bit 6 link pass. A 1 enables a source.
- R3: The receive-polarity source contributes only while link pass is high.
- R4: A write strobe updates bits 14, 7 and 6:0 at the next clock edge. All other bits ignore the written value. Bits 31:16 and 13:8 always read 0.
- R5: Writing bit 15 has no effect on its read value, which follows only the sources.
- R6: With bit 7 clear, the LED is on exactly in the cycles after those where the combined condition is true.
- R7: With bit 7 set, a one-cycle event in cycle t keeps the LED on in cycles t+1 through t+STRETCH_LEN+1. The LED stays on for at least as long as the condition holds.
- R8: A new rising edge of the combined condition reloads the stretch count, even while a stretch is still running.
- R9: Bit 14 = 1 drives the pin high when the LED is on. Bit 14 = 0 drives it low when the LED is on.
- R10: The pin is registered. A source change is not visible on the pin until the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hard reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read word |
| col_i | input | 1 | Collision activity |
| jab_i | input | 1 | Jabber condition |
| rcv_i | input | 1 | Receive activity |
| rxpol_i | input | 1 | Receive polarity reversed |
| xmt_i | input | 1 | Transmit activity |
| rcv_match_i | input | 1 | Address-matched receive activity |
| link_pass_i | input | 1 | Link status pass |
| led_o | output | 1 | LED pin drive |

## Verification
The hardest case to reach is a second rising edge of the combined condition that arrives while an earlier stretch is still counting down. The reload must then extend the pulse instead of letting it expire. The bench shortens the stretch to a few cycles, places strobes mid-stretch on purpose, and runs sparse random strobes across all source masks. A second hard-to-reach case is a reversed receive polarity with the link failed. Directed steps toggle link pass while that source alone is enabled.

// File: rtl/led_drv_pkg.sv
package led_drv_pkg;
  localparam int NUM_SRC = 7;
  localparam int STR_BIT = 7;
  localparam int POL_BIT = 14;
  localparam int RAW_BIT = 15;
  localparam int LINK_IDX = 6;
  localparam int RXPOL_IDX = 3;

  typedef struct packed {
    logic               pol;
    logic               str_en;
    logic [NUM_SRC-1:0] src_en;
  } led_cfg_t;

  localparam led_cfg_t CFG_RESET = '{pol: 1'b0, str_en: 1'b1, src_en: 7'h10};
endpackage

// File: rtl/led_cfg_reg.sv
module led_cfg_reg
  import led_drv_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output led_cfg_t    cfg_o
);
  led_cfg_t cfg_q, cfg_d;
  logic unused_wr_bits;

  assign unused_wr_bits = ^{wr_data_i[31:POL_BIT+1], wr_data_i[POL_BIT-1:STR_BIT+1]};

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en_i) begin
      cfg_d.pol    = wr_data_i[POL_BIT];
      cfg_d.str_en = wr_data_i[STR_BIT];
      cfg_d.src_en = wr_data_i[NUM_SRC-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= CFG_RESET;
    else         cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(cfg_o));
  p_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (cfg_o.pol == $past(wr_data_i[POL_BIT])) &&
                (cfg_o.src_en == $past(wr_data_i[NUM_SRC-1:0])));
endmodule

// File: rtl/led_src_mux.sv
module led_src_mux
  import led_drv_pkg::*;
(
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic               raw_o
);
  logic [NUM_SRC-1:0] eff;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    if (g == RXPOL_IDX) begin : g_gated
      // polarity reversal is meaningful only with link up
      assign eff[g] = src_i[g] & src_i[LINK_IDX] & en_i[g];
    end else begin : g_plain
      assign eff[g] = src_i[g] & en_i[g];
    end
  end

  assign raw_o = |eff;

  always_comb begin
    if (!src_i[LINK_IDX] && en_i == (NUM_SRC'(1) << RXPOL_IDX))
      p_pol_gate_r3: assert (!raw_o);
  end
endmodule

// File: rtl/led_stretch.sv
module led_stretch #(
  parameter int unsigned STRETCH_LEN = 32'd1 << 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic evt_i,
  output logic active_o
);
  localparam int CW = $clog2(STRETCH_LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(STRETCH_LEN);

  logic [CW-1:0] cnt_q;
  logic          evt_q;
  logic          rise;

  assign rise = evt_i & ~evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      evt_q <= 1'b0;
    end else begin
      evt_q <= evt_i;
      if (!en_i)             cnt_q <= '0;
      else if (rise)         cnt_q <= LOAD;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active_o = evt_i | (cnt_q != '0);

  p_reload_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && evt_i && !evt_q) |=> cnt_q == LOAD);
  p_count_down_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !(evt_i && !evt_q) && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  p_idle_when_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
endmodule

// File: rtl/led_status_drv.sv
module led_status_drv
  import led_drv_pkg::*;
#(
  parameter int unsigned STRETCH_LEN = 32'd1 << 20
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  input  logic        col_i,
  input  logic        jab_i,
  input  logic        rcv_i,
  input  logic        rxpol_i,
  input  logic        xmt_i,
  input  logic        rcv_match_i,
  input  logic        link_pass_i,
  output logic        led_o
);
  led_cfg_t           cfg;
  logic [NUM_SRC-1:0] src;
  logic               raw;
  logic               led_on;
  logic               led_q;

  assign src = {link_pass_i, rcv_match_i, xmt_i, rxpol_i, rcv_i, jab_i, col_i};

  led_cfg_reg i_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .cfg_o(cfg)
  );

  led_src_mux i_mux (
    .src_i(src), .en_i(cfg.src_en), .raw_o(raw)
  );

  led_stretch #(.STRETCH_LEN(STRETCH_LEN)) i_str (
    .clk_i, .rst_ni, .en_i(cfg.str_en), .evt_i(raw), .active_o(led_on)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) led_q <= ~CFG_RESET.pol;
    else         led_q <= cfg.pol ? led_on : ~led_on;
  end

  assign led_o = led_q;

  always_comb begin
    rd_data_o                 = '0;
    rd_data_o[RAW_BIT]        = raw;
    rd_data_o[POL_BIT]        = cfg.pol;
    rd_data_o[STR_BIT]        = cfg.str_en;
    rd_data_o[NUM_SRC-1:0]    = cfg.src_en;
  end

  p_pin_level_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> led_o == ($past(cfg.pol) ~^ $past(led_on)));
  p_raw_lights_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw |=> led_o == $past(cfg.pol));
  p_reserved_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[31:16] == 16'h0 && rd_data_o[13:8] == 6'h0);
endmodule

// File: tb/test_led_status_drv.sv
`timescale 1ns/1ps
module test_led_status_drv;
  localparam int unsigned L = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [6:0]  s = '0;
  logic        led;

  int errors = 0;
  int checks = 0;

  logic       m_pol = 1'b0;
  logic       m_str = 1'b1;
  logic [6:0] m_en  = 7'h10;
  logic       m_prev = 1'b0;
  int         m_cnt = 0;
  string      led_tag = "R6";

  always #4 clk = ~clk;

  led_status_drv #(.STRETCH_LEN(L)) i_led_status_drv (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .col_i(s[0]), .jab_i(s[1]), .rcv_i(s[2]),
    .rxpol_i(s[3]), .xmt_i(s[4]), .rcv_match_i(s[5]), .link_pass_i(s[6]),
    .led_o(led)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic comb_exp(input logic [6:0] src, input logic [6:0] en);
    logic [6:0] e;
    e = src;
    if (!src[6]) e[3] = 1'b0;
    return |(e & en);
  endfunction

  // one cycle: inputs applied at negedge, checks read word, then LED after edge
  task automatic step(input logic [6:0] src, input logic w, input logic [31:0] d);
    logic c, on, lexp;
    s = src; wr_en = w; wr_data = d;
    #1;
    c = comb_exp(src, m_en);
    chk("R2", 32'(rd_data[15]), 32'(c));
    chk("R4", {rd_data[31:16], rd_data[14:0]},
        {16'h0, m_pol, 6'h0, m_str, m_en});
    on = c || (m_cnt != 0);
    lexp = m_pol ? on : ~on;
    if (!m_str) m_cnt = 0;
    else if (c && !m_prev) m_cnt = L;
    else if (m_cnt != 0) m_cnt--;
    m_prev = c;
    if (w) begin m_pol = d[14]; m_str = d[7]; m_en = d[6:0]; end
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    chk(led_tag, 32'(led), 32'(lexp));
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int on_cycles;
    repeat (3) @(negedge clk);
    chk("R1", rd_data, 32'h0000_0090);
    chk("R1", 32'(led), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: single transmit strobe with default config
    led_tag = "R7";
    step(7'h10, 1'b0, '0);
    on_cycles = 0;
    for (int i = 0; i < L + 4; i++) begin
      step(7'h00, 1'b0, '0);
      if (led == 1'b0) on_cycles++;
    end
    chk("R7", on_cycles, L);

    // R8: second strobe mid-stretch extends pulse
    led_tag = "R8";
    step(7'h10, 1'b0, '0);
    for (int i = 0; i < 4; i++) step(7'h00, 1'b0, '0);
    step(7'h10, 1'b0, '0);
    on_cycles = 0;
    for (int i = 0; i < L + 4; i++) begin
      step(7'h00, 1'b0, '0);
      if (led == 1'b0) on_cycles++;
    end
    chk("R8", on_cycles, L);

    // R6 / R9: no stretch, active high, collision only
    led_tag = "R6";
    step(7'h00, 1'b1, 32'h0000_4001);
    led_tag = "R9";
    step(7'h01, 1'b0, '0);
    chk("R9", 32'(led), 32'd1);
    step(7'h00, 1'b0, '0);
    chk("R6", 32'(led), 32'd0);

    // R10: pin does not follow until the edge
    s = 7'h01;
    #1;
    chk("R10", 32'(led), 32'd0);
    led_tag = "R10";
    step(7'h01, 1'b0, '0);
    step(7'h00, 1'b0, '0);

    // R3: polarity source gated by link
    led_tag = "R3";
    step(7'h00, 1'b1, 32'h0000_4008);
    step(7'h08, 1'b0, '0);
    chk("R3", 32'(rd_data[15]), 32'd0);
    step(7'h48, 1'b0, '0);
    chk("R3", 32'(led), 32'd1);

    // R4 / R5: reserved and read-only bits ignore writes
    led_tag = "R5";
    step(7'h00, 1'b1, 32'hFFFF_BF00);
    step(7'h00, 1'b0, '0);
    chk("R5", 32'(rd_data[15]), 32'd0);
    chk("R4", rd_data, 32'h0000_0000);

    // random phase
    led_tag = "R7";
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic [6:0] src;
      logic w;
      logic [31:0] d;
      src = 7'($urandom) & 7'($urandom) & 7'($urandom);
      w = ($urandom % 40) == 0;
      d = $urandom;
      step(src, w, d);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule